// File: doc/BRIEF.md
# SDRAM Row Activation Scheduler

This block sits between a memory request source and the command pins of a four-bank SDRAM. For every bank it records whether a row is open and which one. It accepts one request at a time, with an operation (open row, read, write, close row), a bank, a row and a column. It grants the request only when the bank state and all activation timing windows allow it. Each grant becomes one registered command on the next cycle. In every cycle without a grant the command output is a no-operation, so the gap between a row opening and its first access is filled with idle commands.

Timing limits are given as picosecond parameters together with the clock period. They are converted at elaboration into whole cycles, always rounded up. Each bank has its own activate-to-access counter and its own activate-to-activate counter. A single shared counter spaces row openings across different banks. A request that may not yet be issued is held: the grant stays low until the request becomes legal or the requester withdraws it. The block never reorders requests.

Top module: `sdram_act_sched`

## Requirements
- R1: During and directly after reset every bank is closed, the command output is NOP (code 0), and the grant is low while no request is presented.
- R2: A read (op 1) or write (op 2) is granted only when its bank has an open row equal to the requested row. Otherwise it is held, including for a closed bank or a row mismatch.
- R3: A read or write to a bank is granted no earlier than RCD cycles after the grant of the activate to that bank. RCD is ceil(TRCD_PS/TCK_PS), which is 3 with the defaults (20000/7000), and the grant comes exactly then if the request is already waiting.
- R4: An activate (op 0) to a bank that already has an open row is held until a precharge to that bank has been granted.
- R5: Two activates to the same bank are granted at least RC = ceil(TRC_PS/TCK_PS) cycles apart (9 with the defaults). A precharge does not shorten this window.
- R6: Two activates to any banks are granted at least RRD = ceil(TRRD_PS/TCK_PS) cycles apart (2 with the defaults), while accesses to an open bank stay possible in between.
- R7: A grant in cycle n drives, in cycle n+1, cmd_code (1 activate, 2 read, 3 write, 4 precharge), cmd_bank, and cmd_addr (the row for an activate, the zero-extended column for a read or write, zero for a precharge). Cycles that follow a cycle without a grant carry NOP.
- R8: A precharge (op 3) is granted in the cycle it is presented and closes the bank. A precharge to a closed bank changes nothing, so a later read to that bank is still held.
- R9: The grant is combinational, in the same cycle as a legal request, and at most one command is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| req_bank | input | BANK_W (2) | Target bank |
| req_row | input | ROW_W (12) | Row address |
| req_col | input | COL_W (9) | Column address |
| req_ready | output | 1 | Request granted this cycle |
| cmd_code | output | 3 | 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE |
| cmd_bank | output | BANK_W (2) | Bank of the issued command |
| cmd_addr | output | ROW_W (12) | Row or column of the issued command |

## Verification
Two checks can meet in the same cycle. The activate-to-access window of one bank can end in the cycle where the shared activate spacing blocks an activate to another bank. Likewise, the per-bank activate-to-activate window can run out in the same cycle as the shared window. The bench provokes these meetings with directed back-to-back activates to different banks, followed at once by accesses and by reopening a bank right after closing it. Randomly mixed sequences over all banks add further cases. For every request the bench computes the earliest legal cycle from its own record of past grants, and it requires the grant to fall in exactly that cycle, with the matching command one cycle later.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // Whole cycles needed to cover a time limit, rounded up, never below one.
  function automatic int cyc_of(input int limit_ps, input int period_ps);
    int c;
    c = (limit_ps + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/cyc_down_counter.sv
module cyc_down_counter #(
  parameter int LOAD_CYC = 3,
  localparam int CW = (LOAD_CYC < 2) ? 1 : $clog2(LOAD_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ok
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = CW'(LOAD_CYC - 1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ok = (cnt_q == '0);
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int ROW_W   = 12,
  parameter int RCD_CYC = 3,
  parameter int RC_CYC  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic             pre_fire,
  input  logic             rw_fire,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rcd_ok,
  output logic             rc_ok
);
  logic open_d;

  always_comb begin
    open_d = is_open;
    if (act_fire)      open_d = 1'b1;
    else if (pre_fire) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) is_open <= 1'b0;
    else        is_open <= open_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        open_row <= '0;
    else if (act_fire) open_row <= act_row;
  end

  cyc_down_counter #(.LOAD_CYC(RCD_CYC)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(act_fire), .ok(rcd_ok));

  cyc_down_counter #(.LOAD_CYC(RC_CYC)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(act_fire), .ok(rc_ok));

  // Checker: independent count of cycles since this bank's last activate.
  localparam int SW = $clog2(RC_CYC + 1);
  logic [SW-1:0] since_act;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_act <= SW'(RC_CYC);
    else if (act_fire)                  since_act <= SW'(1);
    else if (int'(since_act) < RC_CYC)  since_act <= since_act + 1'b1;
  end

  AST_RW_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    rw_fire |-> is_open); // R2
  AST_RW_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
    rw_fire |-> (int'(since_act) >= RCD_CYC)); // R3
  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> !is_open); // R4
  AST_ACT_AFTER_RC: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> (int'(since_act) >= RC_CYC)); // R5
endmodule

// File: rtl/sdram_act_sched.sv
module sdram_act_sched
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int TCK_PS    = 7000,
  parameter int TRCD_PS   = 20000,
  parameter int TRC_PS    = 60000,
  parameter int TRRD_PS   = 12000,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_addr
);
  localparam int RCD_CYC = cyc_of(TRCD_PS, TCK_PS);
  localparam int RC_CYC  = cyc_of(TRC_PS, TCK_PS);
  localparam int RRD_CYC = cyc_of(TRRD_PS, TCK_PS);

  logic [NUM_BANKS-1:0] bk_open, bk_rcd_ok, bk_rc_ok;
  logic [ROW_W-1:0]     bk_row [NUM_BANKS];
  logic                 rrd_ok;
  logic                 grant, act_fire, pre_fire, rw_fire;
  req_op_e              op;
  cmd_e                 code_d;
  logic [ROW_W-1:0]     addr_d;

  assign op = req_op_e'(req_op);

  // Grant decision from bank state and timing windows.
  always_comb begin
    grant = 1'b0;
    if (req_valid) begin
      unique case (op)
        OP_ACT:       grant = !bk_open[req_bank] && bk_rc_ok[req_bank] && rrd_ok;
        OP_RD, OP_WR: grant = bk_open[req_bank] && (bk_row[req_bank] == req_row)
                              && bk_rcd_ok[req_bank];
        default:      grant = 1'b1;
      endcase
    end
  end

  assign req_ready = grant;
  assign act_fire  = grant && (op == OP_ACT);
  assign pre_fire  = grant && (op == OP_PRE);
  assign rw_fire   = grant && ((op == OP_RD) || (op == OP_WR));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (req_bank == BANK_W'(b));
    bank_tracker #(.ROW_W(ROW_W), .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_fire (act_fire && hit),
      .pre_fire (pre_fire && hit),
      .rw_fire  (rw_fire && hit),
      .act_row  (req_row),
      .is_open  (bk_open[b]),
      .open_row (bk_row[b]),
      .rcd_ok   (bk_rcd_ok[b]),
      .rc_ok    (bk_rc_ok[b])
    );
  end

  cyc_down_counter #(.LOAD_CYC(RRD_CYC)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(act_fire), .ok(rrd_ok));

  // Next command.
  always_comb begin
    code_d = CMD_NOP;
    addr_d = '0;
    if (grant) begin
      unique case (op)
        OP_ACT:  begin code_d = CMD_ACT; addr_d = req_row; end
        OP_RD:   begin code_d = CMD_RD;  addr_d = ROW_W'(req_col); end
        OP_WR:   begin code_d = CMD_WR;  addr_d = ROW_W'(req_col); end
        default: begin code_d = CMD_PRE; addr_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_code <= CMD_NOP;
    else        cmd_code <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_bank <= '0;
      cmd_addr <= '0;
    end else if (grant) begin
      cmd_bank <= req_bank;
      cmd_addr <= addr_d;
    end
  end

  // Checker: cycles since any activate, for the cross-bank window.
  localparam int GW = $clog2(RRD_CYC + 1);
  logic [GW-1:0] since_any;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_any <= GW'(RRD_CYC);
    else if (act_fire)                  since_any <= GW'(1);
    else if (int'(since_any) < RRD_CYC) since_any <= since_any + 1'b1;
  end

  AST_ACT_AFTER_RRD: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> (int'(since_any) >= RRD_CYC)); // R6
  AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (cmd_code == 3'd0)); // R7
  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ready); // R9
  AST_PRE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |-> req_ready); // R8
endmodule

// File: tb/sdram_act_sched_tb_top.sv
`timescale 1ns/1ps
module sdram_act_sched_tb_top;
  localparam int RCD = 3;
  localparam int RC  = 9;
  localparam int RRD = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [8:0]  req_col;
  logic        req_ready;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_act [4];
  int last_any;
  bit open_m [4];
  int row_m [4];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_act_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_ready(req_ready), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Earliest legal grant cycle for a request first presented in cycle now.
  function automatic int exp_grant(input int op, input int b, input int now);
    if (op == 0) return max2(now, max2(last_act[b] + RC, last_any + RRD));
    if (op == 3) return now;
    return max2(now, last_act[b] + RCD);
  endfunction

  // Present a request that will become legal; check grant cycle and command.
  task automatic issue(input int op, input int b, input int row, input int col, input string req);
    int exp_c, g, waited;
    req_valid = 1'b1; req_op = 2'(op); req_bank = 2'(b);
    req_row = 12'(row); req_col = 9'(col);
    exp_c = exp_grant(op, b, cyc);
    waited = 0;
    #1;
    while (!req_ready && waited < 40) begin
      @(negedge clk);
      check(cmd_code == 3'd0, "R7 idle NOP", cmd_code, 0);
      waited++;
      #1;
    end
    g = cyc;
    check(req_ready && g == exp_c, req, g, exp_c);
    @(negedge clk);
    check(cmd_code == 3'(op + 1), "R7 code", cmd_code, op + 1);
    check(cmd_bank == 2'(b), "R7 bank", cmd_bank, b);
    check(cmd_addr == ((op == 0) ? 12'(row) : (op == 3) ? 12'd0 : 12'(col)),
          "R7 addr", cmd_addr, (op == 0) ? row : (op == 3) ? 0 : col);
    req_valid = 1'b0;
    if (op == 0) begin
      open_m[b] = 1'b1; row_m[b] = row; last_act[b] = g; last_any = g;
    end else if (op == 3) begin
      open_m[b] = 1'b0;
    end
  endtask

  // Present an illegal request for n cycles; it must never be granted.
  task automatic hold(input int op, input int b, input int row, input int n, input string req);
    req_valid = 1'b1; req_op = 2'(op); req_bank = 2'(b);
    req_row = 12'(row); req_col = 9'd5;
    for (int i = 0; i < n; i++) begin
      #1;
      check(!req_ready, req, req_ready, 0);
      @(negedge clk);
      check(cmd_code == 3'd0, "R7 NOP while held", cmd_code, 0);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4; i++) begin
      last_act[i] = -1000; open_m[i] = 1'b0; row_m[i] = 0;
    end
    last_any = -1000;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_bank = '0;
    req_row = '0; req_col = '0;
    repeat (3) @(negedge clk);
    check(cmd_code == 3'd0, "R1 NOP in reset", cmd_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!req_ready, "R1 no grant idle", req_ready, 0);
    check(cmd_code == 3'd0, "R1 NOP after reset", cmd_code, 0);
    @(negedge clk);

    hold(1, 0, 5, 4, "R2 read to closed bank held");
    issue(0, 0, 5, 0, "R6 first activate");
    issue(1, 0, 5, 17, "R3 read waits RCD");
    hold(2, 0, 6, 3, "R2 row mismatch held");
    issue(0, 1, 9, 0, "R6 cross-bank activate spacing");
    issue(0, 2, 33, 0, "R6 back-to-back activates");
    issue(2, 1, 9, 100, "R3 write after RCD");
    hold(0, 0, 7, 3, "R4 activate to open bank held");
    issue(3, 0, 0, 0, "R8 precharge immediate");
    issue(0, 0, 7, 0, "R5 reopen waits RC");
    issue(3, 3, 0, 0, "R8 precharge closed bank");
    hold(1, 3, 0, 3, "R8 closed bank stays closed");
    issue(1, 0, 7, 511, "R3 read max column");

    for (int k = 0; k < 300; k++) begin
      int b, r;
      b = int'($urandom % 4);
      r = int'($urandom % 4096);
      if (!open_m[b]) begin
        if ($urandom % 4 != 0) issue(0, b, r, 0, "R5 R6 random activate");
        else                   issue(3, b, 0, 0, "R8 random precharge");
      end else begin
        case ($urandom % 5)
          0, 1:    issue(1, b, row_m[b], int'($urandom % 512), "R3 random read");
          2:       issue(2, b, row_m[b], int'($urandom % 512), "R3 random write");
          default: issue(3, b, 0, 0, "R8 random precharge");
        endcase
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule